// File: doc/BRIEF.md
# SDI Word Aligner and Timing Reference Decoder

This block sits behind a deserializer and descrambler in a serial digital video receiver. Its input is a stream of parallel words whose bit boundaries can be shifted by any amount. It looks at every possible bit offset for the timing preamble: one word of all ones followed by two words of all zeros. It locks onto the offset where that preamble is found and shifts every later word into its correct position. It then presents aligned words with a strobe on the first preamble word. From the protected word that follows the preamble it decodes a field bit, a vertical-blanking bit and a horizontal-blanking bit, and holds them until the next such word.

Two lane widths are supported. The standard-definition lane is 10 bits wide. The high-definition lane is 20 bits wide and carries two interleaved 10-bit channels, which send the preamble at the same time. A saturating error counter records preambles seen at an offset other than the one in use, as well as protected words that fail their check. A later rate-lock decision can read this count. The lane width (`hd_mode`) may only change while reset is held.

Top module: `sdi_word_aligner`

## Requirements
- R1: Input words form one serial bit stream in least-significant-bit-first order: bit 0 of word n+1 follows bit W-1 of word n, where W is 10 (SD, using `word_in[9:0]`) or 20 (HD). The preamble is found at every bit offset from 0 to W-1. In SD it is 3FFh, 000h, 000h. In HD it is FFFFFh, 00000h, 00000h.
- R2: After reset the offset in use is 0. A preamble found at a different offset is adopted only if the preamble found just before it had that same offset. Neither of those two preambles raises the strobe.
- R3: Latency is fixed. A word that starts in input word n at the offset in use appears on `word_out` after the fourth clock edge following the edge that captured input word n.
- R4: `trs_mark` is high for exactly the one cycle in which the first preamble word (3FFh in SD, FFFFFh in HD) is on `word_out`, and only for preambles at the offset in use.
- R5: The protected word is the third word after the first preamble word. Its bit layout is: bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1:0 = 0. In HD both 10-bit channels must hold the same value. When the word is valid, `fld_flag`, `vblk_flag` and `hblk_flag` take F, V and H in the same cycle that the word is on `word_out`. H = 1 marks end of active video and H = 0 marks start of active video.
- R6: The three flags keep their value between protected words.
- R7: When a protected word is invalid, `xyz_bad` pulses for one cycle while that word is on `word_out`, and the flags stay unchanged.
- R8: `align_err_cnt` increases by one for each preamble found at an offset other than the one in use and for each `xyz_bad` pulse. It saturates at 2^CNT_W-1.
- R9: In SD mode `word_out[19:10]` is always zero.
- R10: Synchronous active-low reset clears every output to zero.
- R11: A single preamble at another offset, between preambles at the locked offset, does not move the alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_mode | input | 1 | 1 selects the 20-bit lane, 0 the 10-bit lane |
| word_in | input | 20 | Raw deserialized words |
| word_out | output | 20 | Aligned words |
| trs_mark | output | 1 | First preamble word is on `word_out` |
| fld_flag | output | 1 | Held field bit |
| vblk_flag | output | 1 | Held vertical-blanking bit |
| hblk_flag | output | 1 | Held horizontal-blanking bit (1 after end of active video) |
| xyz_bad | output | 1 | Protected word failed its check |
| align_err_cnt | output | 8 | Saturating alignment and timing error count |

## Verification
Both lane widths are swept over every bit offset, using streams of lines that alternate end-of-active and start-of-active preambles with different flag values. This separates immediate lock at offset 0 from the two-preamble adoption path at every other offset, and it pins down latency and flag timing. A stream that holds one misplaced preamble and then a lasting bit slip shows the difference between an ignored stray pattern and a genuine realignment. Protected words with a flipped protection bit or mismatched HD channels test the error pulse and flag retention, and a long run of bad words drives the counter into saturation.

// File: rtl/sdi_align_pkg.sv
// Shared constants and helpers for the SDI word aligner.
// Assumes the HD lane is exactly two 10-bit channels wide.
package sdi_align_pkg;

    localparam int LANE_SD = 10;
    localparam int LANE_HD = 20;

    // Held timing flags decoded from the protected word.
    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    // Builds the protected 10-bit word for given F, V, H bits.
    function automatic logic [9:0] xyz_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/sdi_word_history.sv
// Four-deep register history of raw input words.
// Provides the search windows for both lane widths and the
// barrel-shifted aligned word for the offset in use.
// Assumes off_sel stays below the active lane width.
module sdi_word_history #(
    parameter int SD_W  = 10,
    parameter int HD_W  = 20,
    parameter int OFF_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hd_mode,
    input  logic [HD_W-1:0]     word_in,
    input  logic [OFF_W-1:0]    off_sel,
    output logic [4*HD_W-1:0]   win_hd,
    output logic [4*SD_W-1:0]   win_sd,
    output logic [HD_W-1:0]     aligned
);
    localparam int DEPTH = 4;
    localparam int PAD   = 2*HD_W - 2*SD_W;

    logic [HD_W-1:0] hist [DEPTH];

    // Newest word enters at the top slot.
    always_ff @(posedge clk) begin
        if (!rst_n) hist[DEPTH-1] <= '0;
        else        hist[DEPTH-1] <= word_in;
    end

    genvar i;
    generate
        for (i = 0; i < DEPTH-1; i++) begin : g_shift
            // Each slot takes the next newer word.
            always_ff @(posedge clk) begin
                if (!rst_n) hist[i] <= '0;
                else        hist[i] <= hist[i+1];
            end
        end
        for (i = 0; i < DEPTH; i++) begin : g_win
            assign win_hd[i*HD_W +: HD_W] = hist[i];
            assign win_sd[i*SD_W +: SD_W] = hist[i][SD_W-1:0];
        end
    endgenerate

    logic [2*HD_W-1:0] pair_hd;
    logic [2*HD_W-1:0] pair_sd;
    logic [HD_W-1:0]   al_hd;
    logic [SD_W-1:0]   al_sd;

    // Barrel shift of the two oldest words by the offset in use.
    always_comb begin
        pair_hd = {hist[1], hist[0]};
        pair_sd = {{PAD{1'b0}}, hist[1][SD_W-1:0], hist[0][SD_W-1:0]};
        al_hd   = pair_hd[off_sel +: HD_W];
        al_sd   = pair_sd[off_sel +: SD_W];
        aligned = hd_mode ? al_hd : {{(HD_W-SD_W){1'b0}}, al_sd};
    end

endmodule

// File: rtl/sdi_trs_finder.sv
// Searches a window of four lane words for the preamble
// (W ones followed by 2W zeros) at every offset 0..W-1.
// A preamble can match at no more than one offset, so the index is unambiguous.
module sdi_trs_finder #(
    parameter int W     = 10,
    parameter int OFF_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4*W-1:0]     win,
    output logic               hit,
    output logic [OFF_W-1:0]   idx
);
    logic [W-1:0] match;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_off
            assign match[k] = (&win[k +: W]) && !(|win[k+W +: 2*W]);
        end
    endgenerate

    // Converts the match vector into the offset index.
    always_comb begin
        idx = '0;
        for (int j = 0; j < W; j++) begin
            if (match[j]) idx = OFF_W'(j);
        end
    end

    assign hit = |match;

    // R1: the preamble matches at no more than one offset.
    p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/sdi_xyz_decoder.sv
// Checks the protected word that follows a preamble and holds
// the F, V, H flags until the next valid protected word.
// An invalid word raises a one-cycle error pulse and leaves the flags unchanged.
// Assumes HD_W == 2*SD_W (two channels in HD).
module sdi_xyz_decoder
    import sdi_align_pkg::*;
#(
    parameter int SD_W = 10,
    parameter int HD_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hd_mode,
    input  logic            take,
    input  logic [HD_W-1:0] word,
    output tflags_t         flags,
    output logic            bad
);
    logic [SD_W-1:0] lo;
    logic [SD_W-1:0] hi;
    logic            ok;

    // Validity: correct layout and protection, channels equal in HD.
    always_comb begin
        lo = word[SD_W-1:0];
        hi = word[HD_W-1:SD_W];
        ok = (lo == xyz_word(lo[8], lo[7], lo[6])) && (!hd_mode || hi == lo);
    end

    // Updates held flags on valid words and pulses on invalid ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            bad   <= 1'b0;
        end else begin
            bad <= take && !ok;
            if (take && ok) flags <= '{f: lo[8], v: lo[7], h: lo[6]};
        end
    end

    // R6: flags move only after a decode slot.
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(flags));

    // R7: an error pulse never coincides with a flag change.
    p_bad_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> $stable(flags));

endmodule

// File: rtl/sdi_word_aligner.sv
// Word aligner and preamble decoder for a 10-bit SD or 20-bit HD lane.
// Locks a bit offset after two consecutive preambles at the same
// offset, realigns the stream, marks the first preamble word, decodes
// the protected word and counts alignment and timing errors.
// The data and the strobe/flag outputs share one output register stage.
// Assumes hd_mode changes only while reset is held.
module sdi_word_aligner
    import sdi_align_pkg::*;
#(
    parameter int SD_W  = LANE_SD,
    parameter int HD_W  = LANE_HD,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_mode,
    input  logic [HD_W-1:0]   word_in,
    output logic [HD_W-1:0]   word_out,
    output logic              trs_mark,
    output logic              fld_flag,
    output logic              vblk_flag,
    output logic              hblk_flag,
    output logic              xyz_bad,
    output logic [CNT_W-1:0]  align_err_cnt
);
    localparam int OFF_W = $clog2(HD_W);
    localparam logic [CNT_W:0]  CNT_MAX = {1'b0, {CNT_W{1'b1}}};
    localparam logic [HD_W-1:0] SD_ONES = {{(HD_W-SD_W){1'b0}}, {SD_W{1'b1}}};
    localparam logic [1:0] PH_IDLE = 2'd0;
    localparam logic [1:0] PH_XYZ  = 2'd3;

    logic [4*HD_W-1:0] win_hd;
    logic [4*SD_W-1:0] win_sd;
    logic [HD_W-1:0]   aligned;
    logic [OFF_W-1:0]  off_use;
    logic [OFF_W-1:0]  off_last;
    logic              last_vld;
    logic              hit_sd, hit_hd, det_hit;
    logic [OFF_W-1:0]  idx_sd, idx_hd, det_idx;
    logic              strobe, misalign, adopt;
    logic [1:0]        phase;
    logic              take;
    tflags_t           flags;
    logic [CNT_W:0]    cnt_sum;

    sdi_word_history #(.SD_W(SD_W), .HD_W(HD_W), .OFF_W(OFF_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .hd_mode (hd_mode),
        .word_in (word_in),
        .off_sel (off_use),
        .win_hd  (win_hd),
        .win_sd  (win_sd),
        .aligned (aligned)
    );

    sdi_trs_finder #(.W(SD_W), .OFF_W(OFF_W)) u_find_sd (
        .clk (clk), .rst_n (rst_n), .win (win_sd), .hit (hit_sd), .idx (idx_sd)
    );

    sdi_trs_finder #(.W(HD_W), .OFF_W(OFF_W)) u_find_hd (
        .clk (clk), .rst_n (rst_n), .win (win_hd), .hit (hit_hd), .idx (idx_hd)
    );

    // Classifies a detection against the offset in use and the previous detection.
    always_comb begin
        det_hit  = hd_mode ? hit_hd : hit_sd;
        det_idx  = hd_mode ? idx_hd : idx_sd;
        strobe   = det_hit && (det_idx == off_use);
        misalign = det_hit && (det_idx != off_use);
        adopt    = misalign && last_vld && (det_idx == off_last);
        take     = (phase == PH_XYZ);
    end

    // Offset lock: remember every detection, adopt on a repeated offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_use  <= '0;
            off_last <= '0;
            last_vld <= 1'b0;
        end else if (det_hit) begin
            off_last <= det_idx;
            last_vld <= 1'b1;
            if (adopt) off_use <= det_idx;
        end
    end

    // Counts words after an aligned preamble to find the protected word.
    always_ff @(posedge clk) begin
        if (!rst_n)                            phase <= PH_IDLE;
        else if (strobe)                       phase <= 2'd1;
        else if (phase != PH_IDLE && !take)    phase <= phase + 2'd1;
        else                                   phase <= PH_IDLE;
    end

    sdi_xyz_decoder #(.SD_W(SD_W), .HD_W(HD_W)) u_xyz (
        .clk     (clk),
        .rst_n   (rst_n),
        .hd_mode (hd_mode),
        .take    (take),
        .word    (aligned),
        .flags   (flags),
        .bad     (xyz_bad)
    );

    // Output register stage for data and strobe, level with the flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            trs_mark <= 1'b0;
        end else begin
            word_out <= aligned;
            trs_mark <= strobe;
        end
    end

    // Saturating error count of misplaced preambles and bad protected words.
    always_comb cnt_sum = {1'b0, align_err_cnt} + (CNT_W+1)'(misalign) + (CNT_W+1)'(xyz_bad);

    always_ff @(posedge clk) begin
        if (!rst_n)                 align_err_cnt <= '0;
        else if (cnt_sum > CNT_MAX) align_err_cnt <= CNT_MAX[CNT_W-1:0];
        else                        align_err_cnt <= cnt_sum[CNT_W-1:0];
    end

    assign fld_flag  = flags.f;
    assign vblk_flag = flags.v;
    assign hblk_flag = flags.h;

    // R4: the strobe sits on a first preamble word.
    p_strobe_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trs_mark |-> (word_out == (hd_mode ? {HD_W{1'b1}} : SD_ONES)));

    // R4: the strobe lasts one cycle.
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trs_mark |=> !trs_mark);

    // R9: the upper half is zero in SD mode.
    p_sd_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_mode |-> (word_out[HD_W-1:SD_W] == '0));

    // R2: the offset moves only on a repeated foreign offset.
    p_offset_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adopt |=> $stable(off_use));

    // R1: the offset in use stays inside the lane.
    p_offset_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        off_use < OFF_W'(HD_W));

    // R8: the error count never decreases outside reset.
    p_count_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> align_err_cnt >= $past(align_err_cnt));

endmodule

// File: tb/tb_sdi_word_aligner.sv
module tb_sdi_word_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hd_mode = 1'b0;
    logic [19:0] word_in = '0;
    logic [19:0] word_out;
    logic        trs_mark, fld_flag, vblk_flag, hblk_flag, xyz_bad;
    logic [7:0]  align_err_cnt;

    always #2 clk = ~clk;

    sdi_word_aligner dut (
        .clk (clk), .rst_n (rst_n), .hd_mode (hd_mode), .word_in (word_in),
        .word_out (word_out), .trs_mark (trs_mark), .fld_flag (fld_flag),
        .vblk_flag (vblk_flag), .hblk_flag (hblk_flag), .xyz_bad (xyz_bad),
        .align_err_cnt (align_err_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [16383:0] bits;
    int             nb;
    int             tpos [0:511];
    logic [19:0]    txyz [0:511];
    bit             tgood[0:511];
    int             nt;

    logic [19:0] o_dat [0:2047];
    logic        o_trs [0:2047];
    logic [2:0]  o_flg [0:2047];
    logic        o_xe  [0:2047];
    logic [7:0]  o_cnt [0:2047];
    int          ncyc;

    function automatic int lw();
        return hd_mode ? 20 : 10;
    endfunction

    function automatic logic [9:0] mk_xyz(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    function automatic logic [19:0] xw(input logic [9:0] x);
        return hd_mode ? {x, x} : {10'b0, x};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        nb = 0;
        nt = 0;
    endtask

    task automatic pbits(input logic [19:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            bits[nb] = v[i];
            nb++;
        end
    endtask

    task automatic palt(input int n);
        for (int i = 0; i < n; i++) begin
            bits[nb] = (i % 2 == 0);
            nb++;
        end
    endtask

    task automatic ptrs(input logic [19:0] x);
        tpos[nt]  = nb;
        txyz[nt]  = x;
        tgood[nt] = (x[9:0] == mk_xyz(x[8], x[7], x[6])) && (!hd_mode || x[19:10] == x[9:0]);
        nt++;
        pbits(20'hFFFFF, lw());
        pbits(20'h00000, lw());
        pbits(20'h00000, lw());
        pbits(x, lw());
    endtask

    function automatic logic [19:0] payw(input int i);
        logic [9:0] a;
        a = 10'h200 | 10'(i * 7);
        return hd_mode ? {10'h300 | 10'(i), a} : {10'b0, a};
    endfunction

    task automatic ppay(input int n);
        for (int i = 0; i < n; i++) pbits(payw(i), lw());
    endtask

    task automatic line(input logic f, input logic v);
        ptrs(xw(mk_xyz(f, v, 1'b1)));
        ppay(5);
        ptrs(xw(mk_xyz(f, v, 1'b0)));
        ppay(5);
    endtask

    function automatic logic [19:0] rawword(input int n);
        logic [19:0] r;
        r = '0;
        for (int b = 0; b < lw(); b++) begin
            if (n * lw() + b < nb) r[b] = bits[n * lw() + b];
        end
        return r;
    endfunction

    // Resets the design (checking R10), plays the stream, records outputs per edge.
    task automatic run();
        int nw;
        @(negedge clk);
        rst_n   = 1'b0;
        word_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word_out == '0 && !trs_mark && !xyz_bad && align_err_cnt == '0 &&
            {fld_flag, vblk_flag, hblk_flag} == 3'b000, "R10 reset state",
            {word_out, 3'b0, trs_mark, xyz_bad, fld_flag, vblk_flag, hblk_flag, align_err_cnt[5:0]}, 32'h0);
        rst_n = 1'b1;
        nw    = (nb + lw() - 1) / lw();
        ncyc  = (nw + 8 < 2048) ? nw + 8 : 2048;
        for (int n = 0; n < ncyc; n++) begin
            word_in = rawword(n);
            @(posedge clk);
            @(negedge clk);
            o_dat[n] = word_out;
            o_trs[n] = trs_mark;
            o_flg[n] = {fld_flag, vblk_flag, hblk_flag};
            o_xe[n]  = xyz_bad;
            o_cnt[n] = align_err_cnt;
        end
    endtask

    function automatic logic [2:0] fl(input int t);
        return {txyz[t][8], txyz[t][7], txyz[t][6]};
    endfunction

    // Checks one preamble expected at the locked offset; pg = last good preamble or -1.
    task automatic check_locked(input int t, input int pg);
        int c;
        logic [19:0] ones;
        c    = tpos[t] / lw() + 4;
        ones = hd_mode ? 20'hFFFFF : 20'h003FF;
        chk(o_trs[c] === 1'b1, "R4 strobe on first word", 32'(o_trs[c]), 32'd1);
        chk(o_dat[c] === ones, "R3 first word latency", 32'(o_dat[c]), 32'(ones));
        chk(o_dat[c+3] === txyz[t], "R3 protected word", 32'(o_dat[c+3]), 32'(txyz[t]));
        if (pg >= 0)
            chk(o_flg[c+2] === fl(pg), "R6 flags held", 32'(o_flg[c+2]), 32'(fl(pg)));
        if (tgood[t]) begin
            chk(o_flg[c+3] === fl(t), "R5 flags decoded", 32'(o_flg[c+3]), 32'(fl(t)));
            chk(o_xe[c+3] === 1'b0, "R5 no error on valid word", 32'(o_xe[c+3]), 32'd0);
        end else begin
            chk(o_xe[c+3] === 1'b1, "R7 error pulse", 32'(o_xe[c+3]), 32'd1);
            if (pg >= 0)
                chk(o_flg[c+3] === fl(pg), "R7 flags unchanged", 32'(o_flg[c+3]), 32'(fl(pg)));
        end
    endtask

    function automatic int count_strobes();
        int s;
        s = 0;
        for (int n = 0; n < ncyc; n++) if (o_trs[n]) s++;
        return s;
    endfunction

    task automatic check_no_strobe(input int t, input string req);
        int c;
        c = tpos[t] / lw() + 4;
        for (int d = -1; d <= 1; d++)
            chk(o_trs[c+d] === 1'b0, req, 32'(o_trs[c+d]), 32'd0);
    endtask

    // R1 R2 R3: sweep one lane width over one bit offset.
    task automatic sweep(input logic hdv, input int s);
        int first;
        int sd_up;
        hd_mode = hdv;
        clr();
        palt(s);
        for (int l = 0; l < 3; l++) line(l[0], l[1]);
        run();
        first = (s == 0) ? 0 : 2;
        for (int t = 0; t < first; t++) check_no_strobe(t, "R2 no strobe before lock");
        for (int t = first; t < nt; t++) check_locked(t, (t > first) ? t - 1 : -1);
        chk(count_strobes() == nt - first, "R1 strobe count", 32'(count_strobes()), 32'(nt - first));
        chk(o_cnt[ncyc-1] == 8'(first), "R8 misaligned count", 32'(o_cnt[ncyc-1]), 32'(first));
        if (!hdv) begin
            sd_up = 0;
            for (int n = 0; n < ncyc; n++) if (o_dat[n][19:10] != 10'b0) sd_up++;
            chk(sd_up == 0, "R9 SD upper zero", 32'(sd_up), 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 R2 R3 R4 R5 R6: every offset in both lanes.
        for (int s = 0; s < 10; s++) sweep(1'b0, s);
        for (int s = 0; s < 20; s++) sweep(1'b1, s);

        // R11 then R2: a stray preamble, then a lasting slip (SD, offset 3).
        hd_mode = 1'b0;
        clr();
        palt(3);
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        palt(5);
        ptrs(xw(mk_xyz(1'b1, 1'b1, 1'b1)));
        palt(5);
        line(1'b0, 1'b1);
        palt(4);
        line(1'b1, 1'b1);
        line(1'b0, 1'b0);
        run();
        check_locked(2, -1);
        check_locked(3, 2);
        check_no_strobe(4, "R11 stray preamble ignored");
        check_locked(5, 3);
        check_locked(6, 5);
        check_no_strobe(7, "R2 first slipped preamble");
        check_no_strobe(8, "R2 adopting preamble");
        check_locked(9, -1);
        check_locked(10, 9);
        chk(count_strobes() == 6, "R11 strobe count", 32'(count_strobes()), 32'd6);
        chk(o_cnt[ncyc-1] == 8'd5, "R8 count after slip", 32'(o_cnt[ncyc-1]), 32'd5);

        // R7: bad protection bit and channel mismatch (HD, offset 11).
        hd_mode = 1'b1;
        clr();
        palt(11);
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        ptrs(xw(mk_xyz(1'b1, 1'b1, 1'b1) ^ 10'h010));
        ppay(5);
        ptrs({mk_xyz(1'b1, 1'b1, 1'b1), mk_xyz(1'b0, 1'b1, 1'b1)});
        ppay(5);
        line(1'b0, 1'b1);
        run();
        check_locked(2, -1);
        check_locked(3, 2);
        check_locked(4, 3);
        check_locked(5, 3);
        check_locked(6, 3);
        check_locked(7, 6);
        chk(o_cnt[ncyc-1] == 8'd4, "R8 count with bad words", 32'(o_cnt[ncyc-1]), 32'd4);

        // R8: saturation with a long run of bad protected words (SD, offset 0).
        hd_mode = 1'b0;
        clr();
        for (int t = 0; t < 260; t++) begin
            ptrs(xw(mk_xyz(1'b0, 1'b1, 1'b0) ^ 10'h004));
            ppay(1);
        end
        run();
        chk(o_cnt[tpos[9] / 10 + 8] == 8'd10, "R8 count after ten errors",
            32'(o_cnt[tpos[9] / 10 + 8]), 32'd10);
        chk(o_cnt[tpos[254] / 10 + 8] == 8'd255, "R8 count reaches max",
            32'(o_cnt[tpos[254] / 10 + 8]), 32'd255);
        chk(o_cnt[ncyc-1] == 8'd255, "R8 count saturated", 32'(o_cnt[ncyc-1]), 32'd255);
        chk(o_xe[tpos[259] / 10 + 7] === 1'b1, "R7 error pulse at saturation",
            32'(o_xe[tpos[259] / 10 + 7]), 32'd1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule